// File: doc/BRIEF.md
# Two-Port Semaphore Token Unit

This block holds a small set of shared ownership flags that two independent ports use to agree on who is currently using a shared resource. Each flag (slot) is either free or held by exactly one port. A port asks for a slot by writing a request to it. It then reads the slot back to learn whether it holds the token. It gives the token up by writing a release value to the same slot.

Both ports run on one clock and may access the same slot in the same cycle. A clash between two requests for a free slot is settled in favour of port A. The losing request is remembered as pending, and the token passes to that port as soon as the holder lets go. No software polling loop is needed for the hand-over itself.

Each port has a select input of its own, which gates all slot accesses on that port. It is the only way to reach the slots.

Top module: `token_semaphore_unit`

## Requirements
- R1: After a synchronous active-low reset, every slot is free with no pending request, and both read outputs are 1.
- R2: A request (a write with data 0) to a free slot grants that slot to the writing port at the clock edge that ends the write cycle.
- R3: When both ports request the same free slot in the same cycle, port A is granted and port B's request is left pending.
- R4: When the holder releases a slot (a write with data 1) while the other port has a pending request, or makes one in that same cycle, the slot passes directly to the other port. The pending mark is then cleared.
- R5: A release by the holder with no competing request frees the slot.
- R6: A write of 1 by a port that does not hold the slot leaves ownership unchanged. If that port had a pending request, the write withdraws it. A request by the holder for its own slot changes nothing.
- R7: A request by the non-holder while the slot is held changes nothing visible except that it marks the request pending. Slots are independent of each other. Reads change no state.
- R8: A read cycle (select 1, write 0) sets that port's data output at the closing clock edge: 0 if the reading port held the slot before that edge, 1 otherwise. The output holds its value in cycles without a read.
- R9: With its select at 0, a port's write strobe, index and data have no effect on any slot or on its read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel | input | 1 | Port A slot access select |
| a_wr | input | 1 | Port A write strobe (1 write, 0 read) |
| a_idx | input | IDX_W (3) | Port A slot index |
| a_din | input | 1 | Port A write data: 0 request, 1 release |
| a_dout | output | 1 | Port A readback: 0 means port A holds the slot |
| b_sel | input | 1 | Port B slot access select |
| b_wr | input | 1 | Port B write strobe (1 write, 0 read) |
| b_idx | input | IDX_W (3) | Port B slot index |
| b_din | input | 1 | Port B write data: 0 request, 1 release |
| b_dout | output | 1 | Port B readback: 0 means port B holds the slot |

## Verification
Every result is due exactly one clock edge after the cycle that presents it. A write's effect on ownership is visible to a read issued in the next cycle. A read's value appears on the data output right after the edge that ends the read cycle, and it reflects ownership as it stood before that edge. The bench drives each cycle's inputs just after a rising edge, keeps a model of holders and pending marks in step with the requirements, and compares both outputs 1 ns after the following edge. A long pseudo-random sweep over all eight slots and all access kinds on both ports follows directed sequences for ties, hand-overs, withdrawals and deselected ports.

// File: rtl/tok_sem_pkg.sv
// Package: shared types for the two-port semaphore token unit.
// Assumes: two ports only, named A (wins ties) and B.
package tok_sem_pkg;

    // Holder of one slot.
    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_A    = 2'd1,
        HOLD_B    = 2'd2
    } holder_t;

    // Write data meaning.
    localparam logic DIN_REQUEST = 1'b0;
    localparam logic DIN_RELEASE = 1'b1;

endpackage

// File: rtl/tok_port_decode.sv
// Module: tok_port_decode
// Turns one port's access into one-hot request and release strobes per slot.
// Assumes: at most one access per port per cycle; no access when sel is low.
module tok_port_decode #(
    parameter int NSLOT = 8,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic             sel,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic             din,
    output logic [NSLOT-1:0] req_vec,
    output logic [NSLOT-1:0] rel_vec,
    output logic             rd_en
);
    import tok_sem_pkg::*;

    logic wr_en;

    // Qualify the write and read strobes by the port select.
    always_comb begin
        wr_en = sel & wr;
        rd_en = sel & ~wr;
    end

    // One decoder leg per slot.
    for (genvar i = 0; i < NSLOT; i++) begin : g_leg
        logic hit;
        assign hit        = wr_en & (idx == IDX_W'(i));
        assign req_vec[i] = hit & (din == DIN_REQUEST);
        assign rel_vec[i] = hit & (din == DIN_RELEASE);
    end
endmodule

// File: rtl/tok_slot.sv
// Module: tok_slot
// One semaphore slot: tracks its holder and a pending request from the
// non-holding port. Port A wins a tie on a free slot.
// Assumes: request and release of one port are never both high.
module tok_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic rel_a,
    input  logic req_b,
    input  logic rel_b,
    output logic held_a,
    output logic held_b,
    output logic wait_a,
    output logic wait_b
);
    import tok_sem_pkg::*;

    holder_t holder_q, holder_d;
    logic    wait_a_q, wait_a_d;
    logic    wait_b_q, wait_b_d;
    logic    a_wants, b_wants;

    // Does the non-holder still want the slot after this cycle's write.
    always_comb begin
        a_wants = req_a | (wait_a_q & ~rel_a);
        b_wants = req_b | (wait_b_q & ~rel_b);
    end

    // Next-state rules for holder and pending marks.
    always_comb begin
        holder_d = holder_q;
        wait_a_d = wait_a_q;
        wait_b_d = wait_b_q;
        unique case (holder_q)
            HOLD_NONE: begin
                wait_a_d = 1'b0;
                wait_b_d = 1'b0;
                if (req_a) begin
                    holder_d = HOLD_A;
                    wait_b_d = req_b;
                end else if (req_b) begin
                    holder_d = HOLD_B;
                end
            end
            HOLD_A: begin
                wait_a_d = 1'b0;
                if (rel_a) begin
                    holder_d = b_wants ? HOLD_B : HOLD_NONE;
                    wait_b_d = 1'b0;
                end else begin
                    wait_b_d = b_wants;
                end
            end
            HOLD_B: begin
                wait_b_d = 1'b0;
                if (rel_b) begin
                    holder_d = a_wants ? HOLD_A : HOLD_NONE;
                    wait_a_d = 1'b0;
                end else begin
                    wait_a_d = a_wants;
                end
            end
            default: begin
                holder_d = HOLD_NONE;
                wait_a_d = 1'b0;
                wait_b_d = 1'b0;
            end
        endcase
    end

    // Slot state registers with synchronous reset to free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holder_q <= HOLD_NONE;
            wait_a_q <= 1'b0;
            wait_b_q <= 1'b0;
        end else begin
            holder_q <= holder_d;
            wait_a_q <= wait_a_d;
            wait_b_q <= wait_b_d;
        end
    end

    // Expose holder and pending state.
    always_comb begin
        held_a = (holder_q == HOLD_A);
        held_b = (holder_q == HOLD_B);
        wait_a = wait_a_q;
        wait_b = wait_b_q;
    end
endmodule

// File: rtl/tok_readback.sv
// Module: tok_readback
// Registered read result for one port: 0 when the port holds the read slot.
// Assumes: held_vec shows ownership before the current edge.
module tok_readback #(
    parameter int NSLOT = 8,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [NSLOT-1:0] held_vec,
    output logic             dout
);
    logic mine;

    // Select the reading port's own ownership bit for the read slot.
    always_comb mine = held_vec[idx];

    // Capture the read result; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= 1'b1;
        else if (rd_en) dout <= ~mine;
    end
endmodule

// File: rtl/token_semaphore_unit.sv
// Module: token_semaphore_unit (top)
// Eight (NSLOT) shared ownership slots for two ports. Writes request or
// release; reads report ownership one edge later.
// Assumes: both ports share clk; NSLOT is a power of two.
module token_semaphore_unit #(
    parameter int NSLOT = 8,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_sel,
    input  logic             a_wr,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             a_din,
    output logic             a_dout,
    input  logic             b_sel,
    input  logic             b_wr,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             b_din,
    output logic             b_dout
);
    logic [NSLOT-1:0] req_a_vec, rel_a_vec, req_b_vec, rel_b_vec;
    logic [NSLOT-1:0] own_a_vec, own_b_vec, wait_a_vec, wait_b_vec;
    logic             a_rd_en, b_rd_en;

    // Port A access decode.
    tok_port_decode #(.NSLOT(NSLOT)) u_dec_a (
        .sel(a_sel), .wr(a_wr), .idx(a_idx), .din(a_din),
        .req_vec(req_a_vec), .rel_vec(rel_a_vec), .rd_en(a_rd_en)
    );

    // Port B access decode.
    tok_port_decode #(.NSLOT(NSLOT)) u_dec_b (
        .sel(b_sel), .wr(b_wr), .idx(b_idx), .din(b_din),
        .req_vec(req_b_vec), .rel_vec(rel_b_vec), .rd_en(b_rd_en)
    );

    // One slot per index.
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        tok_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .req_a(req_a_vec[i]), .rel_a(rel_a_vec[i]),
            .req_b(req_b_vec[i]), .rel_b(rel_b_vec[i]),
            .held_a(own_a_vec[i]), .held_b(own_b_vec[i]),
            .wait_a(wait_a_vec[i]), .wait_b(wait_b_vec[i])
        );
    end

    // Port A readback.
    tok_readback #(.NSLOT(NSLOT)) u_rb_a (
        .clk(clk), .rst_n(rst_n), .rd_en(a_rd_en), .idx(a_idx),
        .held_vec(own_a_vec), .dout(a_dout)
    );

    // Port B readback.
    tok_readback #(.NSLOT(NSLOT)) u_rb_b (
        .clk(clk), .rst_n(rst_n), .rd_en(b_rd_en), .idx(b_idx),
        .held_vec(own_b_vec), .dout(b_dout)
    );
endmodule

// File: rtl/tok_sem_checker.sv
// Module: tok_sem_checker
// Temporal checks on the semaphore unit, bound to the top module.
// Assumes: synchronous active-low reset; NSLOT a power of two.
module tok_sem_checker #(
    parameter int NSLOT = 8,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_sel,
    input logic             a_wr,
    input logic [IDX_W-1:0] a_idx,
    input logic             a_din,
    input logic             a_dout,
    input logic             b_sel,
    input logic             b_wr,
    input logic [IDX_W-1:0] b_idx,
    input logic             b_din,
    input logic             b_dout,
    input logic [NSLOT-1:0] own_a_vec,
    input logic [NSLOT-1:0] own_b_vec,
    input logic [NSLOT-1:0] wait_b_vec
);
    logic a_req, a_rel, b_req, b_rel, b_touch_a;

    // Port access classification for the properties.
    always_comb begin
        a_req     = a_sel & a_wr & ~a_din;
        a_rel     = a_sel & a_wr & a_din;
        b_req     = b_sel & b_wr & ~b_din;
        b_rel     = b_sel & b_wr & b_din;
        b_touch_a = b_sel & b_wr & (b_idx == a_idx);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (own_a_vec == '0) && (own_b_vec == '0) && a_dout && b_dout);

    // R2
    grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_req && !own_a_vec[a_idx] && !own_b_vec[a_idx]
        |=> own_a_vec[$past(a_idx)]);

    // R3
    tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_req && b_req && (a_idx == b_idx) && !own_a_vec[a_idx] && !own_b_vec[a_idx]
        |=> own_a_vec[$past(a_idx)] && wait_b_vec[$past(a_idx)]);

    // R4
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rel && own_a_vec[a_idx] && wait_b_vec[a_idx] && !b_touch_a
        |=> own_b_vec[$past(a_idx)] && !wait_b_vec[$past(a_idx)]);

    // R6
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rel && own_b_vec[a_idx] && !b_touch_a
        |=> own_b_vec[$past(a_idx)]);

    // R8
    owner_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_sel && !a_wr && own_a_vec[a_idx] |=> !a_dout);

    // R8
    owner_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_sel && !b_wr && own_b_vec[b_idx] |=> !b_dout);

    // R8
    idle_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_sel && !a_wr) |=> $stable(a_dout));
endmodule

bind token_semaphore_unit tok_sem_checker #(.NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_idx(a_idx), .a_din(a_din), .a_dout(a_dout),
    .b_sel(b_sel), .b_wr(b_wr), .b_idx(b_idx), .b_din(b_din), .b_dout(b_dout),
    .own_a_vec(own_a_vec), .own_b_vec(own_b_vec), .wait_b_vec(wait_b_vec)
);

// File: tb/token_semaphore_unit_test.sv
// Bench: directed sequences plus a pseudo-random sweep against a
// requirement-level model of holders and pending marks.
module token_semaphore_unit_test;
    localparam int NSLOT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_sel = 0, a_wr = 0, a_din = 0;
    logic       b_sel = 0, b_wr = 0, b_din = 0;
    logic [2:0] a_idx = 0, b_idx = 0;
    logic       a_dout, b_dout;

    int tests = 0;
    int fails = 0;

    // Model: 0 free, 1 held by A, 2 held by B.
    int   mh [NSLOT];
    bit   mpa[NSLOT];
    bit   mpb[NSLOT];
    logic exp_a = 1'b1, exp_b = 1'b1;

    always #2.5 clk = ~clk;

    token_semaphore_unit #(.NSLOT(NSLOT)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_wr(a_wr), .a_idx(a_idx), .a_din(a_din), .a_dout(a_dout),
        .b_sel(b_sel), .b_wr(b_wr), .b_idx(b_idx), .b_din(b_din), .b_dout(b_dout)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Advance the model by one cycle from the requirement rules.
    task automatic model_step(input bit ra, input bit la, input int ia,
                              input bit rb, input bit lb, input int ib);
        for (int i = 0; i < NSLOT; i++) begin
            bit qa = ra && ia == i, xa = la && ia == i;
            bit qb = rb && ib == i, xb = lb && ib == i;
            bit aw = qa || (mpa[i] && !xa);
            bit bw = qb || (mpb[i] && !xb);
            if (mh[i] == 0) begin
                mpa[i] = 0; mpb[i] = 0;
                if (qa) begin mh[i] = 1; mpb[i] = qb; end
                else if (qb) mh[i] = 2;
            end else if (mh[i] == 1) begin
                mpa[i] = 0;
                if (xa) begin mh[i] = bw ? 2 : 0; mpb[i] = 0; end
                else mpb[i] = bw;
            end else begin
                mpb[i] = 0;
                if (xb) begin mh[i] = aw ? 1 : 0; mpa[i] = 0; end
                else mpa[i] = aw;
            end
        end
    endtask

    // One bus cycle on both ports, then compare both outputs.
    task automatic step(input bit as, input bit aw, input int ai, input bit ad,
                        input bit bs, input bit bw, input int bi, input bit bd,
                        input string tag);
        a_sel = as; a_wr = aw; a_idx = 3'(ai); a_din = ad;
        b_sel = bs; b_wr = bw; b_idx = 3'(bi); b_din = bd;
        if (as && !aw) exp_a = (mh[ai] == 1) ? 1'b0 : 1'b1;
        if (bs && !bw) exp_b = (mh[bi] == 2) ? 1'b0 : 1'b1;
        model_step(as && aw && !ad, as && aw && ad, ai,
                   bs && bw && !bd, bs && bw && bd, bi);
        @(posedge clk); #1;
        check({tag, " a_dout"}, a_dout, exp_a);
        check({tag, " b_dout"}, b_dout, exp_b);
    endtask

    // Read one slot on both ports.
    task automatic probe(input int i, input string tag);
        step(1, 0, i, 0, 1, 0, i, 0, tag);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < NSLOT; i++) begin mh[i] = 0; mpa[i] = 0; mpb[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset a_dout", a_dout, 1'b1);
        check("R1 reset b_dout", b_dout, 1'b1);
        rst_n = 1'b1;
        for (int i = 0; i < NSLOT; i++) probe(i, "R1 all free");

        // R2: A requests slot 3.
        step(1, 1, 3, 0, 0, 0, 0, 0, "R2 request");
        probe(3, "R2 granted to A");
        // R8: idle cycle holds the last read values.
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8 hold");
        // R9: deselected write on B to slot 5 is ignored.
        step(0, 0, 0, 0, 0, 1, 5, 0, "R9 deselected");
        probe(5, "R9 slot still free");
        // R3: tie on free slot 5.
        step(1, 1, 5, 0, 1, 1, 5, 0, "R3 tie");
        probe(5, "R3 A wins");
        // R4: A releases, pending B takes over.
        step(1, 1, 5, 1, 0, 0, 0, 0, "R4 release");
        probe(5, "R4 B holds");
        // R5: B releases with nobody waiting.
        step(0, 0, 0, 0, 1, 1, 5, 1, "R5 release");
        probe(5, "R5 free");
        // R6: foreign release, withdrawal, own re-request.
        step(0, 0, 0, 0, 1, 1, 3, 1, "R6 foreign release");
        probe(3, "R6 A still holds");
        step(1, 1, 3, 0, 1, 1, 3, 0, "R6 own re-request / R7 pend");
        probe(3, "R7 A still holds");
        step(0, 0, 0, 0, 1, 1, 3, 1, "R6 withdraw");
        step(1, 1, 3, 1, 0, 0, 0, 0, "R6 release after withdraw");
        probe(3, "R6 free after withdraw");
        // R4: release by holder while other requests in the same cycle.
        step(0, 0, 0, 0, 1, 1, 6, 0, "R4 B takes 6");
        step(1, 1, 6, 0, 1, 1, 6, 1, "R4 same-cycle swap");
        probe(6, "R4 A holds 6");
        // R7: other slots untouched.
        for (int i = 0; i < NSLOT; i++) probe(i, "R7 slot independence");

        // Pseudo-random sweep over all slots and access kinds.
        for (int n = 0; n < 6000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[9], lfsr[1], int'(lfsr[4:2]), lfsr[5],
                 lfsr[6] | lfsr[15], lfsr[7], int'({lfsr[8], lfsr[11:10]}), lfsr[12],
                 "R8 sweep");
        end
        for (int i = 0; i < NSLOT; i++) probe(i, "R2 final scan");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule